// File: doc/BRIEF.md
# Doorbell Inter-Processor Interrupt Unit

This unit lets any bus master raise a doorbell on one or more CPUs with a single write. The write goes to a software-interrupt register. The word carries a CPU target bitmap and a doorbell number. Every targeted CPU gets that doorbell bit set in its own inbound register. Each CPU also has a mask register, and its doorbell interrupt line is raised while any inbound bit is both set and unmasked. A read-only "next" register returns the lowest pending doorbell index, which is the one software should service first.

Message-signalled writes, for example from an I/O fabric, arrive on a second write path that uses the same word format. A group-select bit in the word steers a write to a separate message-signalled bank instead of the CPU banks. That bank has its own cause register, its own next register and its own interrupt line. Software clears a bit in either kind of bank by writing a word with a 0 in that bit position. If a clear and a new set of the same bit land in the same cycle, the set wins, so no doorbell is lost.

Top module: `dbu_doorbell`

## Requirements
- R1: After reset, every inbound register, mask register and the message cause register read 0, `db_irq` and `msi_irq` are 0, and every next register reads 0x3FF.
- R2: A bus write to global offset 0x004 with bit 5 = 0 sets bit `wdata[4:0]` in the inbound register of each CPU i for which `wdata[8+i]` is 1. Inbound registers of CPUs that are not targeted do not change.
- R3: A software-interrupt write with bit 5 = 1 sets bit `wdata[4:0]` in the message cause register and changes no CPU inbound register, whatever the target bits hold.
- R4: A write to a CPU's inbound register (page 1+i, offset 0x08) clears every bit written as 0 and keeps every bit written as 1. It never sets a bit.
- R5: A CPU's mask register (page 1+i, offset 0x0C) is written and read back as a whole word, and it changes only on a write to it. Writing all ones unmasks every doorbell.
- R6: `db_irq[i]` is a register output that equals the OR of CPU i's inbound bits ANDed with its mask bits, and it follows that state in the same cycle the state changes.
- R7: A CPU's next register (page 1+i, offset 0x10) returns the index of the lowest set inbound bit, regardless of the mask, or 0x3FF when no bit is set.
- R8: The message cause register (page 0xF, offset 0x00) clears with the same rule as R4, `msi_irq` equals the OR of its bits, and its next register (offset 0x04) returns the lowest set index or 0x3FF.
- R9: When a set and a clear hit the same bit in the same cycle, the bit ends up set. Writes on the bus path and the message path that arrive in the same cycle both take effect.
- R10: A write on `msg_wr` is decoded with the same word format as a bus write to offset 0x004, both for CPU targets and for the group bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Byte address: page in [ADDR_W-1:8], offset in [7:0] |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| msg_wr | input | 1 | Message-signalled write strobe, in software-interrupt format |
| msg_wdata | input | 32 | Message-signalled write data |
| db_irq | output | NUM_CPU | Per-CPU doorbell interrupt, registered |
| msi_irq | output | 1 | Message bank interrupt, registered |

## Verification
A wrong fan-out decode or a stuck inbound bit shows on the inbound and next registers on the first read after the offending write, and on `db_irq` one clock edge after that write. Lost set-versus-clear priority shows as a missing bit right after the colliding cycle. A broken clear-by-zero rule shows as bits that were written 1 disappearing, or bits that were written 0 surviving. Because the interrupt lines are registered from the next state, any disagreement between the interrupt lines and the stored bits is visible at the very next edge.

// File: rtl/dbu_pkg.sv
// Package: shared constants and types for the doorbell unit.
// Assumes 32-bit data words and a byte address split into page and offset.
package dbu_pkg;

    localparam int DATA_W      = 32;
    localparam int OFFS_W      = 8;
    localparam int NUM_FIELD_W = 5;
    localparam int GROUP_BIT   = 5;
    localparam int TGT_LSB     = 8;
    localparam int IDX_W       = 10;

    localparam logic [IDX_W-1:0]  IDX_NONE = 10'h3FF;

    // Offsets inside the pages
    localparam logic [OFFS_W-1:0] OFF_SWI   = 8'h04;
    localparam logic [OFFS_W-1:0] OFF_INB   = 8'h08;
    localparam logic [OFFS_W-1:0] OFF_MASK  = 8'h0C;
    localparam logic [OFFS_W-1:0] OFF_NEXT  = 8'h10;
    localparam logic [OFFS_W-1:0] OFF_CAUSE = 8'h00;
    localparam logic [OFFS_W-1:0] OFF_MNEXT = 8'h04;

    typedef enum logic [1:0] {
        PG_GLOBAL = 2'd0,
        PG_CPU    = 2'd1,
        PG_MSG    = 2'd2,
        PG_NONE   = 2'd3
    } page_kind_e;

    typedef struct packed {
        logic                   grp;
        logic [NUM_FIELD_W-1:0] num;
    } swi_field_t;

endpackage

// File: rtl/dbu_lowest_set.sv
// Module: lowest-set-bit finder.
// Returns the index of the lowest 1 in vec_i, or IDX_NONE when vec_i is zero.
// Assumes W <= 1023 so an index never collides with IDX_NONE.
module dbu_lowest_set
    import dbu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o
);

    // Scan high to low so the last hit, the lowest one, wins
    always_comb begin
        idx_o = IDX_NONE;
        for (int k = W - 1; k >= 0; k--) begin
            if (vec_i[k]) begin
                idx_o = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/dbu_swi_decode.sv
// Module: software-interrupt word decoder.
// Turns the bus and message write words into per-CPU set vectors and a set
// vector for the message bank. Both sources are ORed, so writes arriving in
// the same cycle both land. Assumes NUM_BELL <= 32 and NUM_CPU <= 24.
module dbu_swi_decode
    import dbu_pkg::*;
#(
    parameter int NUM_CPU  = 4,
    parameter int NUM_BELL = 32
) (
    input  logic                             bus_go_i,
    input  logic [DATA_W-1:0]                bus_wdata_i,
    input  logic                             msg_go_i,
    input  logic [DATA_W-1:0]                msg_wdata_i,
    output logic [NUM_CPU-1:0][NUM_BELL-1:0] cpu_set_o,
    output logic [NUM_BELL-1:0]              msg_set_o
);

    swi_field_t bus_f;
    swi_field_t msg_f;

    assign bus_f = '{grp: bus_wdata_i[GROUP_BIT], num: bus_wdata_i[NUM_FIELD_W-1:0]};
    assign msg_f = '{grp: msg_wdata_i[GROUP_BIT], num: msg_wdata_i[NUM_FIELD_W-1:0]};

    logic [NUM_BELL-1:0] bus_onehot;
    logic [NUM_BELL-1:0] msg_onehot;

    // One-hot the doorbell number of each source
    always_comb begin
        bus_onehot = '0;
        msg_onehot = '0;
        for (int k = 0; k < NUM_BELL; k++) begin
            bus_onehot[k] = (bus_f.num == NUM_FIELD_W'(k));
            msg_onehot[k] = (msg_f.num == NUM_FIELD_W'(k));
        end
    end

    // Fan each source out to its targeted CPUs when the group bit is clear
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic bus_tgt;
        logic msg_tgt;
        assign bus_tgt = bus_go_i && !bus_f.grp && bus_wdata_i[TGT_LSB + c];
        assign msg_tgt = msg_go_i && !msg_f.grp && msg_wdata_i[TGT_LSB + c];
        assign cpu_set_o[c] = ({NUM_BELL{bus_tgt}} & bus_onehot)
                            | ({NUM_BELL{msg_tgt}} & msg_onehot);
    end

    // The group bit steers a source to the message bank instead
    assign msg_set_o = ({NUM_BELL{bus_go_i && bus_f.grp}} & bus_onehot)
                     | ({NUM_BELL{msg_go_i && msg_f.grp}} & msg_onehot);

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata_i[DATA_W-1:TGT_LSB+NUM_CPU], bus_wdata_i[TGT_LSB-1:GROUP_BIT+1],
                            msg_wdata_i[DATA_W-1:TGT_LSB+NUM_CPU], msg_wdata_i[TGT_LSB-1:GROUP_BIT+1]};

endmodule

// File: rtl/dbu_bell_bank.sv
// Module: one bank of doorbell bits with an optional mask.
// A bit is set from set_i, and a write clears each bit written as 0
// (bits written 1 keep their value). Set beats clear in the same cycle.
// irq_o is registered from the next state, so it tracks the stored bits
// with no lag. With HAS_MASK = 0 the bank is treated as fully unmasked.
module dbu_bell_bank
    import dbu_pkg::*;
#(
    parameter int W        = 32,
    parameter bit HAS_MASK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     set_i,
    input  logic             clr_we_i,
    input  logic [W-1:0]     clr_data_i,
    input  logic             mask_we_i,
    input  logic [W-1:0]     mask_data_i,
    output logic [W-1:0]     bits_o,
    output logic [W-1:0]     mask_o,
    output logic             irq_o,
    output logic [IDX_W-1:0] next_o
);

    logic [W-1:0] bits_q;
    logic [W-1:0] bits_d;
    logic [W-1:0] mask_d;
    logic         irq_q;

    // Next bit state: apply the clear word first, then OR in new sets
    always_comb begin
        bits_d = clr_we_i ? (bits_q & clr_data_i) : bits_q;
        bits_d = bits_d | set_i;
    end

    if (HAS_MASK) begin : g_mask
        logic [W-1:0] mask_q;

        // Mask register, written as a whole word
        always_comb mask_d = mask_we_i ? mask_data_i : mask_q;

        // Mask storage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
            end else begin
                mask_q <= mask_d;
            end
        end

        assign mask_o = mask_q;
    end else begin : g_nomask
        logic unused_mask;
        assign unused_mask = ^{mask_we_i, mask_data_i};
        assign mask_d = '1;
        assign mask_o = '1;
    end

    // Bit storage and registered interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            bits_q <= bits_d;
            irq_q  <= |(bits_d & mask_d);
        end
    end

    dbu_lowest_set #(.W(W)) u_low (
        .vec_i (bits_q),
        .idx_o (next_o)
    );

    assign bits_o = bits_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/dbu_doorbell.sv
// Module: doorbell inter-processor interrupt unit (top).
// Page 0 holds the software-interrupt register, page 1+i holds CPU i's
// inbound, mask and next registers, and page MSG_PAGE holds the message bank.
// Reads have no side effects, and read data is combinational from the address.
// Assumes NUM_CPU + 1 < MSG_PAGE < 2**(ADDR_W-8).
module dbu_doorbell
    import dbu_pkg::*;
#(
    parameter int NUM_CPU  = 4,
    parameter int NUM_BELL = 32,
    parameter int ADDR_W   = 12,
    parameter int MSG_PAGE = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 msg_wr,
    input  logic [DATA_W-1:0]    msg_wdata,
    output logic [NUM_CPU-1:0]   db_irq,
    output logic                 msi_irq
);

    localparam int PAGE_W = ADDR_W - OFFS_W;

    logic [PAGE_W-1:0] page;
    logic [OFFS_W-1:0] offs;
    page_kind_e        kind;
    logic [PAGE_W-1:0] cpu_sel;

    assign page = bus_addr[ADDR_W-1:OFFS_W];
    assign offs = bus_addr[OFFS_W-1:0];

    // Classify the addressed page
    always_comb begin
        cpu_sel = page - PAGE_W'(1);
        if (page == '0) begin
            kind = PG_GLOBAL;
        end else if (page == PAGE_W'(MSG_PAGE)) begin
            kind = PG_MSG;
        end else if (page <= PAGE_W'(NUM_CPU)) begin
            kind = PG_CPU;
        end else begin
            kind = PG_NONE;
        end
    end

    logic swi_bus_go;
    assign swi_bus_go = bus_wr && (kind == PG_GLOBAL) && (offs == OFF_SWI);

    logic [NUM_CPU-1:0][NUM_BELL-1:0] cpu_set;
    logic [NUM_BELL-1:0]              msg_set;

    dbu_swi_decode #(.NUM_CPU(NUM_CPU), .NUM_BELL(NUM_BELL)) u_dec (
        .bus_go_i    (swi_bus_go),
        .bus_wdata_i (bus_wdata),
        .msg_go_i    (msg_wr),
        .msg_wdata_i (msg_wdata),
        .cpu_set_o   (cpu_set),
        .msg_set_o   (msg_set)
    );

    logic [NUM_CPU-1:0][NUM_BELL-1:0] inb_all;
    logic [NUM_CPU-1:0][NUM_BELL-1:0] msk_all;
    logic [NUM_CPU-1:0][IDX_W-1:0]    next_all;
    logic [NUM_CPU-1:0]               inb_we;
    logic [NUM_CPU-1:0]               mask_we;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic page_hit;
        assign page_hit   = bus_wr && (kind == PG_CPU) && (cpu_sel == PAGE_W'(c));
        assign inb_we[c]  = page_hit && (offs == OFF_INB);
        assign mask_we[c] = page_hit && (offs == OFF_MASK);

        dbu_bell_bank #(.W(NUM_BELL), .HAS_MASK(1'b1)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_i       (cpu_set[c]),
            .clr_we_i    (inb_we[c]),
            .clr_data_i  (bus_wdata[NUM_BELL-1:0]),
            .mask_we_i   (mask_we[c]),
            .mask_data_i (bus_wdata[NUM_BELL-1:0]),
            .bits_o      (inb_all[c]),
            .mask_o      (msk_all[c]),
            .irq_o       (db_irq[c]),
            .next_o      (next_all[c])
        );
    end

    logic [NUM_BELL-1:0] msi_cause;
    logic [NUM_BELL-1:0] msi_mask_unused;
    logic [IDX_W-1:0]    msi_next;
    logic                cause_we;

    assign cause_we = bus_wr && (kind == PG_MSG) && (offs == OFF_CAUSE);

    dbu_bell_bank #(.W(NUM_BELL), .HAS_MASK(1'b0)) u_msg_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (msg_set),
        .clr_we_i    (cause_we),
        .clr_data_i  (bus_wdata[NUM_BELL-1:0]),
        .mask_we_i   (1'b0),
        .mask_data_i ('0),
        .bits_o      (msi_cause),
        .mask_o      (msi_mask_unused),
        .irq_o       (msi_irq),
        .next_o      (msi_next)
    );

    // Read mux: register contents for the addressed page and offset
    always_comb begin
        bus_rdata = '0;
        unique case (kind)
            PG_CPU: begin
                for (int c = 0; c < NUM_CPU; c++) begin
                    if (cpu_sel == PAGE_W'(c)) begin
                        if (offs == OFF_INB)  bus_rdata = DATA_W'(inb_all[c]);
                        if (offs == OFF_MASK) bus_rdata = DATA_W'(msk_all[c]);
                        if (offs == OFF_NEXT) bus_rdata = DATA_W'(next_all[c]);
                    end
                end
            end
            PG_MSG: begin
                if (offs == OFF_CAUSE) bus_rdata = DATA_W'(msi_cause);
                if (offs == OFF_MNEXT) bus_rdata = DATA_W'(msi_next);
            end
            default: bus_rdata = '0;
        endcase
    end

    logic unused_top;
    assign unused_top = ^{msi_mask_unused, bus_wdata};

endmodule

// File: rtl/dbu_doorbell_chk.sv
// Module: assertion checker for dbu_doorbell, attached by bind below.
// Observes the ports and the stored bank state of the top module.
module dbu_doorbell_chk #(
    parameter int NUM_CPU  = 4,
    parameter int NUM_BELL = 32
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             swi_bus_go,
    input logic                             msg_wr,
    input logic [31:0]                      msg_wdata,
    input logic [NUM_CPU-1:0]               mask_we,
    input logic [NUM_CPU-1:0]               db_irq,
    input logic                             msi_irq,
    input logic [NUM_CPU-1:0][NUM_BELL-1:0] inb,
    input logic [NUM_CPU-1:0][NUM_BELL-1:0] msk,
    input logic [NUM_BELL-1:0]              cause
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (db_irq == '0 && !msi_irq && inb == '0 && msk == '0 && cause == '0)); // R1

    AST_SET_NEEDS_SWI: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(swi_bus_go || msg_wr) |-> ((inb & ~$past(inb)) == '0)); // R2

    AST_GROUP_SPARES_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(msg_wr && msg_wdata[5]) && !$past(swi_bus_go)) |-> ((inb & ~$past(inb)) == '0)); // R3

    AST_MSI_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        msi_irq == (|cause)); // R8

    AST_CAUSE_NEEDS_SWI: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(swi_bus_go || msg_wr) |-> ((cause & ~$past(cause)) == '0)); // R8

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            db_irq[c] == (|(inb[c] & msk[c]))); // R6

        AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(mask_we[c]) |-> (msk[c] == $past(msk[c]))); // R5
    end

endmodule

bind dbu_doorbell dbu_doorbell_chk #(.NUM_CPU(NUM_CPU), .NUM_BELL(NUM_BELL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .swi_bus_go (swi_bus_go),
    .msg_wr     (msg_wr),
    .msg_wdata  (msg_wdata),
    .mask_we    (mask_we),
    .db_irq     (db_irq),
    .msi_irq    (msi_irq),
    .inb        (inb_all),
    .msk        (msk_all),
    .cause      (msi_cause)
);

// File: tb/dbu_doorbell_test.sv
// Directed bench for dbu_doorbell: one task per scenario, each checks itself.
module dbu_doorbell_test;

    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msg_wr = 1'b0;
    logic [31:0] msg_wdata = '0;
    logic [NCPU-1:0] db_irq;
    logic        msi_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    dbu_doorbell #(.NUM_CPU(NCPU), .NUM_BELL(32), .ADDR_W(12), .MSG_PAGE(15)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_wr(msg_wr),
        .msg_wdata(msg_wdata), .db_irq(db_irq), .msi_irq(msi_irq)
    );

    localparam logic [11:0] A_SWI   = 12'h004;
    localparam logic [11:0] A_CAUSE = 12'hF00;
    localparam logic [11:0] A_MNEXT = 12'hF04;

    function automatic logic [11:0] a_inb(input int c);  return 12'(((c + 1) << 8) + 8'h08); endfunction
    function automatic logic [11:0] a_mask(input int c); return 12'(((c + 1) << 8) + 8'h0C); endfunction
    function automatic logic [11:0] a_next(input int c); return 12'(((c + 1) << 8) + 8'h10); endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic msg_write(input logic [31:0] d);
        @(negedge clk);
        msg_wr = 1'b1; msg_wdata = d;
        @(negedge clk);
        msg_wr = 1'b0;
    endtask

    task automatic both_write(input logic [11:0] a, input logic [31:0] d, input logic [31:0] m);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        msg_wr = 1'b1; msg_wdata = m;
        @(negedge clk);
        bus_wr = 1'b0; msg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic clear_all();
        for (int c = 0; c < NCPU; c++) begin
            bus_write(a_inb(c), 32'h0);
            bus_write(a_mask(c), 32'h0);
        end
        bus_write(A_CAUSE, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 db_irq", 32'(db_irq), 32'h0);
        check("R1 msi_irq", 32'(msi_irq), 32'h0);
        for (int c = 0; c < NCPU; c++) begin
            bus_read(a_inb(c), v);  check("R1 inbound", v, 32'h0);
            bus_read(a_mask(c), v); check("R1 mask", v, 32'h0);
            bus_read(a_next(c), v); check("R1 next", v, 32'h3FF);
        end
        bus_read(A_CAUSE, v); check("R1 cause", v, 32'h0);
        bus_read(A_MNEXT, v); check("R1 msg next", v, 32'h3FF);
    endtask

    task automatic t_fanout();
        logic [31:0] v;
        clear_all();
        bus_write(A_SWI, (32'h1 << 8) | (32'h1 << 10) | 32'd3);
        bus_read(a_inb(0), v); check("R2 cpu0 targeted", v, 32'h8);
        bus_read(a_inb(1), v); check("R2 cpu1 untouched", v, 32'h0);
        bus_read(a_inb(2), v); check("R2 cpu2 targeted", v, 32'h8);
        bus_read(a_inb(3), v); check("R2 cpu3 untouched", v, 32'h0);
        bus_write(A_SWI, (32'hF << 8) | 32'd31);
        bus_read(a_inb(1), v); check("R2 broadcast bit31", v, 32'h8000_0000);
        bus_read(a_inb(0), v); check("R2 accumulate", v, 32'h8000_0008);
    endtask

    task automatic t_group();
        logic [31:0] v;
        clear_all();
        bus_write(A_SWI, (32'hF << 8) | 32'h20 | 32'd7);
        bus_read(A_CAUSE, v); check("R3 cause set", v, 32'h80);
        for (int c = 0; c < NCPU; c++) begin
            bus_read(a_inb(c), v); check("R3 cpu untouched", v, 32'h0);
        end
        check("R3 msi_irq", 32'(msi_irq), 32'h1);
    endtask

    task automatic t_clear_rule();
        logic [31:0] v;
        clear_all();
        bus_write(A_SWI, (32'h1 << 9) | 32'd3);
        bus_write(A_SWI, (32'h1 << 9) | 32'd9);
        bus_write(a_inb(1), ~(32'h1 << 3));
        bus_read(a_inb(1), v); check("R4 clear bit3 keep bit9", v, 32'h200);
        bus_write(a_inb(1), 32'hFFFF_FFFF);
        bus_read(a_inb(1), v); check("R4 ones do not set", v, 32'h200);
    endtask

    task automatic t_mask_irq();
        logic [31:0] v;
        clear_all();
        bus_write(A_SWI, (32'h1 << 8) | 32'd9);
        check("R6 masked irq low", 32'(db_irq), 32'h0);
        bus_write(a_mask(0), 32'hFFFF_FFFF);
        bus_read(a_mask(0), v); check("R5 mask readback", v, 32'hFFFF_FFFF);
        check("R6 unmasked irq", 32'(db_irq), 32'h1);
        bus_write(a_mask(0), 32'h0000_0001);
        bus_read(a_mask(0), v); check("R5 mask partial", v, 32'h1);
        check("R6 other bit masked", 32'(db_irq), 32'h0);
        bus_write(a_mask(0), 32'h0000_0200);
        check("R6 irq matches mask", 32'(db_irq), 32'h1);
        bus_write(a_inb(0), 32'h0);
        check("R6 irq drops on clear", 32'(db_irq), 32'h0);
    endtask

    task automatic t_next();
        logic [31:0] v;
        clear_all();
        bus_write(A_SWI, (32'h1 << 11) | 32'd20);
        bus_write(A_SWI, (32'h1 << 11) | 32'd6);
        bus_read(a_next(3), v); check("R7 lowest of 6,20", v, 32'd6);
        bus_write(a_inb(3), ~(32'h1 << 6));
        bus_read(a_next(3), v); check("R7 next after clear", v, 32'd20);
        bus_write(a_inb(3), 32'h0);
        bus_read(a_next(3), v); check("R7 none", v, 32'h3FF);
    endtask

    task automatic t_msg_bank();
        logic [31:0] v;
        clear_all();
        bus_write(A_SWI, 32'h20 | 32'd7);
        bus_write(A_SWI, 32'h20 | 32'd2);
        bus_read(A_CAUSE, v); check("R8 cause", v, 32'h84);
        bus_read(A_MNEXT, v); check("R8 msg next", v, 32'd2);
        bus_write(A_CAUSE, 32'h80);
        bus_read(A_CAUSE, v); check("R8 writeback clear", v, 32'h80);
        check("R8 msi_irq held", 32'(msi_irq), 32'h1);
        bus_write(A_CAUSE, 32'h0);
        bus_read(A_MNEXT, v); check("R8 msg next none", v, 32'h3FF);
        check("R8 msi_irq low", 32'(msi_irq), 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        clear_all();
        bus_write(A_SWI, (32'h1 << 8) | 32'd0);
        bus_write(A_SWI, (32'h1 << 8) | 32'd4);
        both_write(a_inb(0), 32'hFFFF_FFEE, (32'h1 << 8) | 32'd0);
        bus_read(a_inb(0), v); check("R9 set beats clear", v, 32'h1);
        both_write(A_SWI, (32'h1 << 9) | 32'd1, (32'h1 << 9) | 32'd5);
        bus_read(a_inb(1), v); check("R9 both sources land", v, 32'h22);
        bus_write(A_CAUSE, 32'h0);
        both_write(A_CAUSE, 32'h0, 32'h20 | 32'd3);
        bus_read(A_CAUSE, v); check("R9 msg set beats clear", v, 32'h8);
    endtask

    task automatic t_msg_path();
        logic [31:0] v;
        clear_all();
        msg_write((32'h1 << 10) | 32'd12);
        bus_read(a_inb(2), v); check("R10 msg fans out", v, 32'h1000);
        bus_read(a_inb(0), v); check("R10 msg not to cpu0", v, 32'h0);
        msg_write((32'hF << 8) | 32'h20 | 32'd30);
        bus_read(A_CAUSE, v); check("R10 msg group", v, 32'h4000_0000);
        bus_read(a_inb(1), v); check("R10 msg group spares cpu", v, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fanout();
        t_group();
        t_clear_rule();
        t_mask_irq();
        t_next();
        t_msg_bank();
        t_set_wins();
        t_msg_path();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung, expected finished run");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule